// File: doc/BRIEF.md
# Dual-Source 128-bit Lane Permute Unit

This unit is one execution stage of a vector datapath. Each beat carries two 256-bit source operands, an 8-bit control byte and two encoding qualifiers (a vector-length bit and a width bit). The 256-bit result is built from two 128-bit destination halves. Each half is picked on its own from the four 128-bit halves of the two sources, or is forced to zero.

The result is held in a single pipeline register and appears one cycle after a beat that has `in_valid` set. Only one qualifier combination is legal. Any other combination produces an undefined-opcode indication and no result write. The unit does no arithmetic, and it produces no status flags and no floating-point exceptions.

Top module: `xlane_permute_unit`

## Requirements
- R1: Control bits [1:0] pick the low result half (result[127:0]). Value 0 selects src_a[127:0], 1 selects src_a[255:128], 2 selects src_b[127:0] and 3 selects src_b[255:128].
- R2: Control bits [5:4] pick the high result half (result[255:128]), using the same 0..3 encoding as R1.
- R3: When control bit 3 is 1, the low result half is all zeros, whatever bits [1:0] hold.
- R4: When control bit 7 is 1, the high result half is all zeros, whatever bits [5:4] hold.
- R5: Control bits 2 and 6 have no effect on any output.
- R6: Both halves may select the same source half, which then appears in both result positions.
- R7: A beat is legal only when `vlen_q`=1 and `width_q`=0. For any other valid beat, one cycle later `out_illegal`=1, `out_wr_en`=0 and `out_result` is all zeros.
- R8: `out_valid` equals the previous cycle's `in_valid`. `out_wr_en` and `out_illegal` are asserted only together with `out_valid`, and exactly one of them is set whenever `out_valid` is 1.
- R9: `out_result` keeps its value across cycles whose input beat has `in_valid`=0, whatever the other inputs do.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_wr_en` and `out_illegal` on the next edge. A beat presented during reset does not load `out_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| src_a | input | 256 | First source operand |
| src_b | input | 256 | Second source operand |
| ctrl | input | 8 | Per-half select and zero control byte |
| vlen_q | input | 1 | Vector-length qualifier (must be 1) |
| width_q | input | 1 | Width qualifier (must be 0) |
| out_valid | output | 1 | Result beat valid |
| out_wr_en | output | 1 | Result write enable (legal beat) |
| out_illegal | output | 1 | Undefined-opcode indication (illegal beat) |
| out_result | output | 256 | Permuted result |

## Verification
Every output of this unit is due exactly one clock edge after the beat that causes it. This holds for the valid, write-enable and illegal flags and for the permuted data. During idle beats the data must stay unchanged, and after reset the flags are due low on the first edge. The bench drives each beat half a period before the edge. A behavioural model predicts, at that same edge, what the outputs must show. The outputs are compared 1 ns after every edge, so each comparison sees the state produced by exactly one preceding beat.

// File: rtl/lperm_pkg.sv
package lperm_pkg;

  localparam int CTRL_W     = 8;
  localparam int FIELD_W    = 4;
  localparam int NUM_HALVES = 2;
  localparam int SEL_W      = 2;
  localparam int ZERO_BIT   = 3;

  typedef enum logic [SEL_W-1:0] {
    HSEL_A_LO = 2'd0,
    HSEL_A_HI = 2'd1,
    HSEL_B_LO = 2'd2,
    HSEL_B_HI = 2'd3
  } hsel_e;

  typedef struct packed {
    logic  zero;
    hsel_e sel;
  } half_ctrl_t;

  // Extract the control field for destination half idx.
  function automatic half_ctrl_t field_of(input logic [CTRL_W-1:0] c, input int idx);
    half_ctrl_t r;
    r.zero = c[idx*FIELD_W + ZERO_BIT];
    r.sel  = hsel_e'(c[idx*FIELD_W +: SEL_W]);
    return r;
  endfunction

endpackage

// File: rtl/lperm_qual_check.sv
module lperm_qual_check #(
  parameter logic LEGAL_VLEN  = 1'b1,
  parameter logic LEGAL_WIDTH = 1'b0
) (
  input  logic vlen_q,
  input  logic width_q,
  output logic legal
);
  assign legal = (vlen_q == LEGAL_VLEN) && (width_q == LEGAL_WIDTH);
endmodule

// File: rtl/lperm_half_mux.sv
module lperm_half_mux
  import lperm_pkg::*;
#(
  parameter int LANE_W = 128
) (
  input  logic [2*LANE_W-1:0] src_a,
  input  logic [2*LANE_W-1:0] src_b,
  input  half_ctrl_t          hc,
  output logic [LANE_W-1:0]   lane
);
  logic [LANE_W-1:0] picked;

  always_comb begin
    unique case (hc.sel)
      HSEL_A_LO: picked = src_a[LANE_W-1:0];
      HSEL_A_HI: picked = src_a[2*LANE_W-1:LANE_W];
      HSEL_B_LO: picked = src_b[LANE_W-1:0];
      HSEL_B_HI: picked = src_b[2*LANE_W-1:LANE_W];
      default:   picked = '0;
    endcase
  end

  assign lane = hc.zero ? '0 : picked;
endmodule

// File: rtl/lperm_stage_reg.sv
module lperm_stage_reg #(
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_legal,
  input  logic [DATA_W-1:0] in_result,
  output logic              out_valid,
  output logic              out_wr_en,
  output logic              out_illegal,
  output logic [DATA_W-1:0] out_result
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_wr_en   <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_wr_en   <= in_valid & in_legal;
      out_illegal <= in_valid & ~in_legal;
    end
  end

  // Data register has no reset so it maps onto plain fabric flops.
  always_ff @(posedge clk) begin
    if (in_valid && !rst) begin
      out_result <= in_legal ? in_result : '0;
    end
  end
endmodule

// File: rtl/xlane_permute_unit.sv
module xlane_permute_unit
  import lperm_pkg::*;
#(
  parameter int LANE_W = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [2*LANE_W-1:0] src_a,
  input  logic [2*LANE_W-1:0] src_b,
  input  logic [CTRL_W-1:0]   ctrl,
  input  logic                vlen_q,
  input  logic                width_q,
  output logic                out_valid,
  output logic                out_wr_en,
  output logic                out_illegal,
  output logic [2*LANE_W-1:0] out_result
);
  localparam int DATA_W = NUM_HALVES * LANE_W;

  logic              legal;
  logic [DATA_W-1:0] perm;

  lperm_qual_check u_qual (
    .vlen_q  (vlen_q),
    .width_q (width_q),
    .legal   (legal)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    half_ctrl_t hc;
    assign hc = field_of(ctrl, h);
    lperm_half_mux #(.LANE_W(LANE_W)) u_mux (
      .src_a (src_a),
      .src_b (src_b),
      .hc    (hc),
      .lane  (perm[h*LANE_W +: LANE_W])
    );
  end

  lperm_stage_reg #(.DATA_W(DATA_W)) u_stage (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_legal    (legal),
    .in_result   (perm),
    .out_valid   (out_valid),
    .out_wr_en   (out_wr_en),
    .out_illegal (out_illegal),
    .out_result  (out_result)
  );
endmodule

// File: rtl/lperm_checker.sv
module lperm_checker #(
  parameter int LANE_W = 128
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [2*LANE_W-1:0] src_a,
  input logic [2*LANE_W-1:0] src_b,
  input logic [7:0]          ctrl,
  input logic                vlen_q,
  input logic                width_q,
  input logic                out_valid,
  input logic                out_wr_en,
  input logic                out_illegal,
  input logic [2*LANE_W-1:0] out_result
);
  logic ok_beat;
  assign ok_beat = in_valid && vlen_q && !width_q;

  a_r1_low_src_a_lo: assert property (@(posedge clk) disable iff (rst)
    ok_beat && !ctrl[3] && ctrl[1:0] == 2'd0 |=> out_result[LANE_W-1:0] == $past(src_a[LANE_W-1:0]));
  a_r1_low_src_b_hi: assert property (@(posedge clk) disable iff (rst)
    ok_beat && !ctrl[3] && ctrl[1:0] == 2'd3 |=> out_result[LANE_W-1:0] == $past(src_b[2*LANE_W-1:LANE_W]));
  a_r2_high_src_a_hi: assert property (@(posedge clk) disable iff (rst)
    ok_beat && !ctrl[7] && ctrl[5:4] == 2'd1 |=> out_result[2*LANE_W-1:LANE_W] == $past(src_a[2*LANE_W-1:LANE_W]));
  a_r2_high_src_b_lo: assert property (@(posedge clk) disable iff (rst)
    ok_beat && !ctrl[7] && ctrl[5:4] == 2'd2 |=> out_result[2*LANE_W-1:LANE_W] == $past(src_b[LANE_W-1:0]));
  a_r3_zero_low: assert property (@(posedge clk) disable iff (rst)
    ok_beat && ctrl[3] |=> out_result[LANE_W-1:0] == '0);
  a_r4_zero_high: assert property (@(posedge clk) disable iff (rst)
    ok_beat && ctrl[7] |=> out_result[2*LANE_W-1:LANE_W] == '0);
  a_r7_illegal_flag: assert property (@(posedge clk) disable iff (rst)
    in_valid && !(vlen_q && !width_q) |=> out_illegal && !out_wr_en && out_result == '0);
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r8_one_flag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({out_wr_en, out_illegal}) == 1);
  a_r8_no_flag_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_wr_en && !out_illegal);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid && !out_wr_en && !out_illegal);
endmodule

bind xlane_permute_unit lperm_checker #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
  .ctrl(ctrl), .vlen_q(vlen_q), .width_q(width_q), .out_valid(out_valid),
  .out_wr_en(out_wr_en), .out_illegal(out_illegal), .out_result(out_result)
);

// File: tb/xlane_permute_unit_tb.sv
`timescale 1ns/1ps
module xlane_permute_unit_tb;
  localparam int LW = 128;
  localparam int DW = 2*LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] src_a = '0;
  logic [DW-1:0] src_b = '0;
  logic [7:0]    ctrl = '0;
  logic          vlen_q = 1'b1;
  logic          width_q = 1'b0;
  logic          out_valid, out_wr_en, out_illegal;
  logic [DW-1:0] out_result;

  always #2.5 clk = ~clk;

  xlane_permute_unit #(.LANE_W(LW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .ctrl(ctrl), .vlen_q(vlen_q), .width_q(width_q), .out_valid(out_valid),
    .out_wr_en(out_wr_en), .out_illegal(out_illegal), .out_result(out_result)
  );

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  string cur_tag = "R10";

  // Behavioural reference model state
  logic          m_valid = 1'b0, m_wr = 1'b0, m_ill = 1'b0, m_known = 1'b0;
  logic [DW-1:0] m_res = '0;
  string         m_tag = "R10";

  function automatic logic [LW-1:0] pick_half(input int code, input logic [DW-1:0] a,
                                              input logic [DW-1:0] b);
    if (code == 0) return a[LW-1:0];
    if (code == 1) return a[DW-1:LW];
    if (code == 2) return b[LW-1:0];
    return b[DW-1:LW];
  endfunction

  function automatic logic [DW-1:0] ref_perm(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                             input logic [7:0] c);
    logic [LW-1:0] lo, hi;
    lo = c[3] ? '0 : pick_half(int'(c[1:0]), a, b);
    hi = c[7] ? '0 : pick_half(int'(c[5:4]), a, b);
    return {hi, lo};
  endfunction

  always @(posedge clk) begin
    m_tag <= cur_tag;
    if (rst) begin
      m_valid <= 1'b0; m_wr <= 1'b0; m_ill <= 1'b0;
    end else begin
      m_valid <= in_valid;
      m_wr    <= in_valid && vlen_q && !width_q;
      m_ill   <= in_valid && !(vlen_q && !width_q);
      if (in_valid) begin
        m_known <= 1'b1;
        m_res   <= (vlen_q && !width_q) ? ref_perm(src_a, src_b, ctrl) : '0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk(out_valid === m_valid, m_tag, "out_valid", DW'(out_valid), DW'(m_valid));
      chk(out_wr_en === m_wr, m_tag, "out_wr_en", DW'(out_wr_en), DW'(m_wr));
      chk(out_illegal === m_ill, m_tag, "out_illegal", DW'(out_illegal), DW'(m_ill));
      if (m_known)
        chk(out_result === m_res, m_tag, "out_result", out_result, m_res);
    end
  end

  function automatic logic [DW-1:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic beat(input logic [7:0] c, input logic vl, input logic w, input string tag);
    @(negedge clk);
    in_valid = 1'b1; src_a = rnd256(); src_b = rnd256();
    ctrl = c; vlen_q = vl; width_q = w; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; src_a = rnd256(); src_b = rnd256();
      ctrl = 8'($urandom); vlen_q = 1'($urandom); width_q = 1'($urandom);
      cur_tag = "R9";
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10: outputs low while in reset
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: every low-half select, high half fixed to src_a low
    for (int s = 0; s < 4; s++) beat(8'(s), 1'b1, 1'b0, "R1");
    // R2: every high-half select
    for (int s = 0; s < 4; s++) beat(8'((s << 4) | 1), 1'b1, 1'b0, "R2");
    // R3 and R4: zero overrides against all selects
    for (int s = 0; s < 4; s++) beat(8'(8'h08 | s | (s << 4)), 1'b1, 1'b0, "R3");
    for (int s = 0; s < 4; s++) beat(8'(8'h80 | s | ((3 - s) << 4)), 1'b1, 1'b0, "R4");
    beat(8'h88, 1'b1, 1'b0, "R3");
    // R5: bits 2 and 6 set with varied selects
    beat(8'h44, 1'b1, 1'b0, "R5");
    beat(8'h67, 1'b1, 1'b0, "R5");
    beat(8'hE6, 1'b1, 1'b0, "R5");
    // R6: duplication into both halves
    for (int s = 0; s < 4; s++) beat(8'(s | (s << 4)), 1'b1, 1'b0, "R6");
    // R9: gaps with noisy inputs
    idle(5);
    beat(8'h31, 1'b1, 1'b0, "R8");
    idle(3);
    // R7: each illegal qualifier pair, between legal beats
    beat(8'h20, 1'b0, 1'b0, "R7");
    beat(8'h13, 1'b1, 1'b1, "R7");
    beat(8'h02, 1'b0, 1'b1, "R7");
    beat(8'h21, 1'b1, 1'b0, "R7");
    idle(2);
    // R10: reset while a beat is offered
    beat(8'h12, 1'b1, 1'b0, "R10");
    @(negedge clk); rst = 1'b1; cur_tag = "R10"; src_a = rnd256(); ctrl = 8'h01;
    @(negedge clk); rst = 1'b0; in_valid = 1'b0; cur_tag = "R9";
    idle(2);
    // R8: mixed random traffic
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      else beat(8'($urandom), ($urandom_range(0, 5) != 0), ($urandom_range(0, 5) == 0), "R8");
    end
    idle(3);
    @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule